// File: doc/BRIEF.md
# Platform Alert and Heartbeat Message Scheduler

This block watches a set of platform event sources and decides when a short status message must go out on a serial management bus. The sources are a cover tamper level, a thermal alarm level, a one-cycle processor-missing report, a one-cycle watchdog expiry, a one-cycle software send-now write strobe, the first firmware fetch byte and one general-purpose input. It also watches a power-state level that is high in the fully working state. Any qualifying event starts an alert. An alert carries a fresh 4-bit sequence number and a status byte. While the system is not in the working state, the block also emits periodic heartbeats that repeat the current sequence number.

The block does not drive the bus wires itself. It raises a transmit request toward a bus engine, and it holds the frame steady while that request is open. The bus engine replies with an idle flag, a collision flag and a completion pulse. A collision withdraws the request. The block then waits for the bus to go idle again and offers the identical frame once more. Events that arrive while a message is in flight are remembered and produce one further alert afterwards.

Top module: `alert_sched`

## Requirements
- R1: `tx_status` packs bit 0 tamper level, bit 1 thermal level, bit 2 processor-missing flag, bit 3 watchdog flag, bit 4 software flag, bit 5 erased-flash flag, bit 6 general-purpose input level, and bit 7 is always 0. Level bits are sampled on the clock edge that launches the message.
- R2: Every change of `gpio_in`, rising or falling, starts an alert. Status bit 6 equals the current level of `gpio_in`.
- R3: A `sw_send_strobe` pulse sets the software flag (bit 4) and starts an alert.
- R4: A `wdog_expire` pulse sets bit 3, and a `cpu_miss_pulse` pulse sets bit 2. Each starts an alert. These two flags and the software flag are cleared once a frame that carried them completes.
- R5: Only the first `fw_fetch_vld` after reset is examined. If its byte is FFh, bit 5 is set until the next reset and an alert starts. Any other byte, and any later fetch, has no effect.
- R6: Reset gives `tx_seq`=0, `tx_status`=0, `busy`=0 and `tx_req`=0. Every alert increments `tx_seq` by one, wrapping from 15 to 0.
- R7: While `pwr_working` is 0, a heartbeat launches after HB_TICKS idle cycles. It counts from the cycle the block last returned to idle, and it reuses the current `tx_seq`. While `pwr_working` is 1, no heartbeat is sent.
- R8: A falling edge of `pwr_working` starts exactly one alert.
- R9: A message that is already launched is carried through to completion even if `pwr_working` rises while it waits.
- R10: `tx_req` rises only after a cycle with `bus_idle` high. A `bus_coll` during a request withdraws it. The same sequence number and status are offered again once the bus is idle.
- R11: `busy` is high from launch until `tx_done` is accepted. `tx_seq` and `tx_status` do not change while `busy` stays high.
- R12: If an event arrives in the same cycle that the heartbeat interval expires, the alert wins and only one message is launched, with an incremented sequence number.
- R13: A falling edge of `tamper_in` or `therm_in` starts nothing. The new level still appears in the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tamper_in | input | 1 | Cover tamper level |
| therm_in | input | 1 | Thermal alarm level |
| cpu_miss_pulse | input | 1 | One-cycle processor-missing report |
| wdog_expire | input | 1 | One-cycle watchdog expiry |
| sw_send_strobe | input | 1 | One-cycle write of 1 to the send-now control |
| fw_fetch_vld | input | 1 | Firmware fetch byte is valid |
| fw_fetch_byte | input | 8 | Firmware fetch data |
| gpio_in | input | 1 | General-purpose event input |
| pwr_working | input | 1 | High in the fully working power state |
| bus_idle | input | 1 | Bus engine reports the bus idle |
| bus_coll | input | 1 | Bus engine reports a collision |
| tx_done | input | 1 | Bus engine reports the frame sent |
| tx_req | output | 1 | Transmit request to the bus engine |
| tx_seq | output | 4 | Frame sequence number |
| tx_status | output | 8 | Frame status byte |
| busy | output | 1 | A message is launched and not yet complete |

## Verification
Two functions can land on one clock edge: the heartbeat interval running out, and a fresh event trigger. The bench provokes this by counting HB_TICKS-1 edges after a completed frame and then toggling the general-purpose input, so that the event lands on the exact expiry edge. The outcome is judged at the ports. Exactly one frame must appear, with an incremented sequence number. No second frame may follow inside the next interval, and the following heartbeat must repeat that new number.

// File: rtl/alert_pkg.sv
package alert_pkg;

    localparam int SEQ_W   = 4;
    localparam int STK_N   = 4;
    localparam int LVL_N   = 4;

    // sticky flag positions
    localparam int STK_CPU   = 0;
    localparam int STK_WDOG  = 1;
    localparam int STK_SW    = 2;
    localparam int STK_BLANK = 3;

    // flags that are cleared once reported
    localparam logic [STK_N-1:0] STK_CLEARABLE = 4'b0111;

    // watched level positions
    localparam int LVL_TAMPER  = 0;
    localparam int LVL_THERM   = 1;
    localparam int LVL_GPIO    = 2;
    localparam int LVL_WORKING = 3;

    localparam logic [7:0] BLANK_BYTE = 8'hFF;

    typedef logic [SEQ_W-1:0] seq_t;

    typedef struct packed {
        logic rsvd;
        logic gpio;
        logic fw_blank;
        logic sw_req;
        logic wdog;
        logic cpu_lost;
        logic thermal;
        logic tamper;
    } alert_status_t;

    typedef enum logic [1:0] {
        TX_IDLE     = 2'd0,
        TX_WAIT_BUS = 2'd1,
        TX_SEND     = 2'd2
    } tx_state_e;

    function automatic alert_status_t build_status(
        input logic tamper, input logic thermal, input logic gpio,
        input logic [STK_N-1:0] stk);
        alert_status_t s;
        s.rsvd     = 1'b0;
        s.gpio     = gpio;
        s.fw_blank = stk[STK_BLANK];
        s.sw_req   = stk[STK_SW];
        s.wdog     = stk[STK_WDOG];
        s.cpu_lost = stk[STK_CPU];
        s.thermal  = thermal;
        s.tamper   = tamper;
        return s;
    endfunction

    function automatic logic [STK_N-1:0] reported_flags(input alert_status_t s);
        logic [STK_N-1:0] r;
        r[STK_CPU]   = s.cpu_lost;
        r[STK_WDOG]  = s.wdog;
        r[STK_SW]    = s.sw_req;
        r[STK_BLANK] = s.fw_blank;
        return r;
    endfunction

endpackage

// File: rtl/alert_edge_det.sv
module alert_edge_det #(
    parameter int W = 4,
    parameter logic [W-1:0] RISE_EN = '1,
    parameter logic [W-1:0] FALL_EN = '0
) (
    input  logic         clk,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] hit
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic prev_q;

        // tracks the input even in reset so release causes no false edge
        always_ff @(posedge clk) begin
            prev_q <= lvl[i];
        end

        if (RISE_EN[i] && FALL_EN[i]) begin : g_any
            assign hit[i] = lvl[i] ^ prev_q;
        end else if (RISE_EN[i]) begin : g_rise
            assign hit[i] = lvl[i] & ~prev_q;
        end else if (FALL_EN[i]) begin : g_fall
            assign hit[i] = ~lvl[i] & prev_q;
        end else begin : g_none
            assign hit[i] = 1'b0;
        end
    end

endmodule

// File: rtl/alert_evt.sv
module alert_evt
    import alert_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tamper_in,
    input  logic              therm_in,
    input  logic              gpio_in,
    input  logic              working,
    input  logic              cpu_miss_pulse,
    input  logic              wdog_expire,
    input  logic              sw_send_strobe,
    input  logic              fw_fetch_vld,
    input  logic [7:0]        fw_fetch_byte,
    input  logic              clr_en,
    input  logic [STK_N-1:0]  clr_flags,
    output alert_status_t     status_now,
    output logic              trig
);

    // rising on tamper/thermal, any edge on gpio, falling on working
    localparam logic [LVL_N-1:0] RISE_MASK = 4'b0111;
    localparam logic [LVL_N-1:0] FALL_MASK = 4'b1100;

    logic [LVL_N-1:0] lvl;
    logic [LVL_N-1:0] lvl_hit;
    logic [STK_N-1:0] stk_q;
    logic [STK_N-1:0] stk_set;
    logic [STK_N-1:0] stk_clr;
    logic             fetched_q;

    always_comb begin
        lvl              = '0;
        lvl[LVL_TAMPER]  = tamper_in;
        lvl[LVL_THERM]   = therm_in;
        lvl[LVL_GPIO]    = gpio_in;
        lvl[LVL_WORKING] = working;
    end

    alert_edge_det #(
        .W       (LVL_N),
        .RISE_EN (RISE_MASK),
        .FALL_EN (FALL_MASK)
    ) u_edges (
        .clk (clk),
        .lvl (lvl),
        .hit (lvl_hit)
    );

    always_comb begin
        stk_set            = '0;
        stk_set[STK_CPU]   = cpu_miss_pulse;
        stk_set[STK_WDOG]  = wdog_expire;
        stk_set[STK_SW]    = sw_send_strobe;
        stk_set[STK_BLANK] = fw_fetch_vld && !fetched_q && (fw_fetch_byte == BLANK_BYTE);
        stk_clr            = clr_en ? (clr_flags & STK_CLEARABLE) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stk_q     <= '0;
            fetched_q <= 1'b0;
        end else begin
            stk_q <= (stk_q & ~stk_clr) | stk_set;
            if (fw_fetch_vld) begin
                fetched_q <= 1'b1;
            end
        end
    end

    assign status_now = build_status(tamper_in, therm_in, gpio_in, stk_q | stk_set);
    assign trig       = (|lvl_hit) || (|stk_set);

endmodule

// File: rtl/alert_hb_timer.sv
module alert_hb_timer #(
    parameter int HB_TICKS = 100000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic fire
);

    localparam int CNT_W = (HB_TICKS > 2) ? $clog2(HB_TICKS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HB_TICKS - 1);

    logic [CNT_W-1:0] cnt_q;

    assign fire = run && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || !run || fire) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/alert_tx_fsm.sv
module alert_tx_fsm
    import alert_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          trig,
    input  logic          beat_fire,
    input  alert_status_t status_in,
    input  logic          bus_idle,
    input  logic          bus_coll,
    input  logic          tx_done,
    output logic          tx_req,
    output logic          busy,
    output logic          idle,
    output logic          done_ok,
    output seq_t          seq,
    output alert_status_t frame
);

    tx_state_e     state_q;
    logic          pend_q;
    seq_t          seq_q;
    alert_status_t frame_q;
    logic          alert_go;
    logic          beat_go;

    assign idle     = (state_q == TX_IDLE);
    assign alert_go = idle && (trig || pend_q);
    assign beat_go  = idle && !alert_go && beat_fire;
    assign done_ok  = (state_q == TX_SEND) && tx_done && !bus_coll;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= TX_IDLE;
            pend_q  <= 1'b0;
            seq_q   <= '0;
            frame_q <= '0;
        end else begin
            if (alert_go) begin
                pend_q <= 1'b0;
            end else if (trig) begin
                pend_q <= 1'b1;
            end

            case (state_q)
                TX_IDLE: begin
                    if (alert_go) begin
                        seq_q   <= seq_q + 1'b1;
                        frame_q <= status_in;
                        state_q <= TX_WAIT_BUS;
                    end else if (beat_go) begin
                        frame_q <= status_in;
                        state_q <= TX_WAIT_BUS;
                    end
                end
                TX_WAIT_BUS: begin
                    if (bus_idle) begin
                        state_q <= TX_SEND;
                    end
                end
                TX_SEND: begin
                    if (bus_coll) begin
                        state_q <= TX_WAIT_BUS;
                    end else if (tx_done) begin
                        state_q <= TX_IDLE;
                    end
                end
                default: state_q <= TX_IDLE;
            endcase
        end
    end

    assign tx_req = (state_q == TX_SEND);
    assign busy   = !idle;
    assign seq    = seq_q;
    assign frame  = frame_q;

endmodule

// File: rtl/alert_sched.sv
module alert_sched
    import alert_pkg::*;
#(
    parameter int HB_TICKS = 100000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tamper_in,
    input  logic       therm_in,
    input  logic       cpu_miss_pulse,
    input  logic       wdog_expire,
    input  logic       sw_send_strobe,
    input  logic       fw_fetch_vld,
    input  logic [7:0] fw_fetch_byte,
    input  logic       gpio_in,
    input  logic       pwr_working,
    input  logic       bus_idle,
    input  logic       bus_coll,
    input  logic       tx_done,
    output logic       tx_req,
    output logic [3:0] tx_seq,
    output logic [7:0] tx_status,
    output logic       busy
);

    alert_status_t status_now;
    alert_status_t frame;
    seq_t          seq;
    logic          trig;
    logic          beat_fire;
    logic          idle;
    logic          done_ok;

    alert_evt u_evt (
        .clk            (clk),
        .rst            (rst),
        .tamper_in      (tamper_in),
        .therm_in       (therm_in),
        .gpio_in        (gpio_in),
        .working        (pwr_working),
        .cpu_miss_pulse (cpu_miss_pulse),
        .wdog_expire    (wdog_expire),
        .sw_send_strobe (sw_send_strobe),
        .fw_fetch_vld   (fw_fetch_vld),
        .fw_fetch_byte  (fw_fetch_byte),
        .clr_en         (done_ok),
        .clr_flags      (reported_flags(frame)),
        .status_now     (status_now),
        .trig           (trig)
    );

    alert_hb_timer #(
        .HB_TICKS (HB_TICKS)
    ) u_hb (
        .clk  (clk),
        .rst  (rst),
        .run  (idle && !pwr_working),
        .fire (beat_fire)
    );

    alert_tx_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .trig      (trig),
        .beat_fire (beat_fire),
        .status_in (status_now),
        .bus_idle  (bus_idle),
        .bus_coll  (bus_coll),
        .tx_done   (tx_done),
        .tx_req    (tx_req),
        .busy      (busy),
        .idle      (idle),
        .done_ok   (done_ok),
        .seq       (seq),
        .frame     (frame)
    );

    assign tx_seq    = seq;
    assign tx_status = frame;

endmodule

// File: rtl/alert_sched_chk.sv
module alert_sched_chk (
    input logic       clk,
    input logic       rst,
    input logic       bus_idle,
    input logic       bus_coll,
    input logic       tx_done,
    input logic       tx_req,
    input logic [3:0] tx_seq,
    input logic [7:0] tx_status,
    input logic       busy
);

    // R10: a request only opens after the bus was seen idle
    p_req_after_idle_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_req) |-> $past(bus_idle));

    // R10: a collision withdraws the request on the next cycle
    p_coll_drop_r10: assert property (@(posedge clk) disable iff (rst)
        (tx_req && bus_coll) |=> !tx_req);

    // R11: frame stays frozen while a message is open
    p_frame_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> ($stable(tx_seq) && $stable(tx_status)));

    // R11: a request never appears outside a busy period
    p_req_in_busy_r11: assert property (@(posedge clk) disable iff (rst)
        tx_req |-> busy);

    // R11: an accepted completion frees the block
    p_done_frees_r11: assert property (@(posedge clk) disable iff (rst)
        (tx_req && tx_done && !bus_coll) |=> !busy);

    // R6, R7: a launch keeps the number (heartbeat) or steps it by one (alert)
    p_seq_step_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> ((tx_seq == $past(tx_seq)) || (tx_seq == $past(tx_seq) + 4'd1)));

    // R1: reserved status bit is zero whenever a frame is offered
    p_rsvd_zero_r1: assert property (@(posedge clk) disable iff (rst)
        tx_req |-> (tx_status[7] == 1'b0));

endmodule

bind alert_sched alert_sched_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_idle  (bus_idle),
    .bus_coll  (bus_coll),
    .tx_done   (tx_done),
    .tx_req    (tx_req),
    .tx_seq    (tx_seq),
    .tx_status (tx_status),
    .busy      (busy)
);

// File: tb/tb_alert_sched.sv
module tb_alert_sched;

    localparam int HB = 40;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tamper_in = 0, therm_in = 0, cpu_miss_pulse = 0, wdog_expire = 0;
    logic       sw_send_strobe = 0, fw_fetch_vld = 0, gpio_in = 0;
    logic [7:0] fw_fetch_byte = 8'h00;
    logic       pwr_working = 1'b1;
    logic       bus_idle = 1'b1, bus_coll = 1'b0, tx_done = 1'b0;
    logic       tx_req, busy;
    logic [3:0] tx_seq;
    logic [7:0] tx_status;

    int nvec = 0;
    int nfail = 0;

    // bench model of flags and sequence
    logic       m_cpu = 0, m_wdog = 0, m_sw = 0, m_blank = 0;
    logic [3:0] eseq = 4'd0;

    always #5 clk = ~clk;

    alert_sched #(.HB_TICKS(HB)) dut (
        .clk(clk), .rst(rst), .tamper_in(tamper_in), .therm_in(therm_in),
        .cpu_miss_pulse(cpu_miss_pulse), .wdog_expire(wdog_expire),
        .sw_send_strobe(sw_send_strobe), .fw_fetch_vld(fw_fetch_vld),
        .fw_fetch_byte(fw_fetch_byte), .gpio_in(gpio_in), .pwr_working(pwr_working),
        .bus_idle(bus_idle), .bus_coll(bus_coll), .tx_done(tx_done),
        .tx_req(tx_req), .tx_seq(tx_seq), .tx_status(tx_status), .busy(busy)
    );

    function automatic logic [7:0] exp_status();
        return {1'b0, gpio_in, m_blank, m_sw, m_wdog, m_cpu, therm_in, tamper_in};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_req(input int max, output bit got);
        got = 0;
        for (int i = 0; i < max; i++) begin
            if (tx_req) begin
                got = 1;
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic quiet(input int n, input string req);
        bit ok = 1;
        repeat (n) begin
            @(negedge clk);
            if (tx_req || busy) ok = 0;
        end
        chk(ok, req, {30'd0, busy, tx_req}, 0);
    endtask

    task automatic serve(input logic [3:0] s, input logic [7:0] st, input int ncoll, input string req);
        bit got;
        wait_req(HB + 20, got);
        chk(got, {req, " request"}, 32'(got), 1);
        if (!got) return;
        chk(tx_seq == s, "R6 seq", tx_seq, s);
        chk(tx_status == st, {"R1 ", req}, tx_status, st);
        for (int c = 0; c < ncoll; c++) begin
            bus_coll = 1; bus_idle = 0;
            @(negedge clk);
            bus_coll = 0;
            repeat (3) @(negedge clk);
            chk(!tx_req && busy, "R10 wait", {30'd0, busy, tx_req}, 2);
            bus_idle = 1;
            wait_req(10, got);
            chk(got && tx_seq == s && tx_status == st, "R10 retry",
                {tx_seq, tx_status}, {s, st});
        end
        tx_done = 1;
        @(negedge clk);
        tx_done = 0;
        chk(!busy, "R11 done", 32'(busy), 0);
        m_cpu = 0; m_wdog = 0; m_sw = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: got timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(tx_seq == 0 && tx_status == 0 && !busy && !tx_req, "R6 reset",
            {tx_seq, tx_status, busy, tx_req}, 0);

        // R5: first fetch not blank, later blank fetch ignored
        fw_fetch_vld = 1; fw_fetch_byte = 8'h3C;
        @(negedge clk); fw_fetch_vld = 0;
        quiet(12, "R5 first");

        // random events in working state
        for (int i = 0; i < 64; i++) begin
            int kind = int'($urandom % 7);
            int nc = int'($urandom % 3);
            bit fire = 0;
            string req = "R2";
            case (kind)
                0: begin tamper_in = ~tamper_in; fire = tamper_in; req = "R13"; end
                1: begin therm_in = ~therm_in; fire = therm_in; req = "R13"; end
                2: begin gpio_in = ~gpio_in; fire = 1; req = "R2"; end
                3: begin cpu_miss_pulse = 1; m_cpu = 1; fire = 1; req = "R4"; end
                4: begin wdog_expire = 1; m_wdog = 1; fire = 1; req = "R4"; end
                5: begin sw_send_strobe = 1; m_sw = 1; fire = 1; req = "R3"; end
                default: begin fw_fetch_vld = 1; fw_fetch_byte = 8'hFF; req = "R5"; end
            endcase
            @(negedge clk);
            cpu_miss_pulse = 0; wdog_expire = 0; sw_send_strobe = 0; fw_fetch_vld = 0;
            if (fire) begin
                eseq = eseq + 4'd1;
                serve(eseq, exp_status(), nc, req);
            end else begin
                quiet(12, req);
            end
        end

        // R8: leave working state, one alert then heartbeat
        pwr_working = 0;
        eseq = eseq + 4'd1;
        serve(eseq, exp_status(), 0, "R8");
        quiet(HB - 5, "R8 single");
        serve(eseq, exp_status(), 1, "R7 beat");

        // R12: event on the exact heartbeat expiry edge
        repeat (HB - 1) @(negedge clk);
        gpio_in = ~gpio_in;
        eseq = eseq + 4'd1;
        serve(eseq, exp_status(), 0, "R12 alert");
        quiet(HB - 5, "R12 single");
        serve(eseq, exp_status(), 0, "R12 beat");

        // R9: enter working while heartbeat waits for the bus
        bus_idle = 0;
        begin
            bit seen = 0;
            for (int i = 0; i < HB + 10; i++) begin
                @(negedge clk);
                if (busy) begin seen = 1; break; end
            end
            chk(seen, "R7 launch", 32'(seen), 1);
        end
        pwr_working = 1;
        repeat (4) @(negedge clk);
        chk(busy, "R9 kept", 32'(busy), 1);
        bus_idle = 1;
        serve(eseq, {1'b0, gpio_in, 2'b00, 2'b00, therm_in, tamper_in} | exp_status(), 0, "R9");
        quiet(3 * HB, "R7 suppressed");

        // reset mid-run, blank first fetch, then new alert after reset
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(tx_seq == 0 && tx_status == 0 && !busy, "R6 rereset", {tx_seq, tx_status}, 0);
        fw_fetch_vld = 1; fw_fetch_byte = 8'hFF; m_blank = 1;
        @(negedge clk); fw_fetch_vld = 0;
        serve(4'd1, exp_status(), 1, "R5 blank");
        cpu_miss_pulse = 1; m_cpu = 1;
        @(negedge clk); cpu_miss_pulse = 0;
        serve(4'd2, exp_status(), 0, "R4 after reset");

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

endmodule